// File: doc/BRIEF.md
# Performance Counter Alert Controller

This block keeps a small bank of event counters and the monitor control bits that decide when the counters stop and when software is alerted. Each counter has its own increment strobe and advances by one per strobe, unless the global freeze bit is set. Software can load any counter or the control register at any time, and a load lands on the next clock edge.

An alert occurs when any counter becomes negative, that is, when its top bit goes from 0 to 1. The cause can be an increment or a software load. In the same clock edge the alert does several things together. It turns the freeze-on-alert bit into the freeze bit. It turns the alert-enable bit into the alert-occurred bit. It raises a request toward the event-based branch dispatcher. Each conversion is one-shot: once its source bit is cleared, later alerts leave the bits alone. The request stays pending until the dispatcher acknowledges it.

Top module: `perf_alert_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every counter, every control bit and `irq_o` are cleared to 0.
- R2: While control bit 0 (freeze) is 0, a high `inc_i[i]` makes counter i exactly one larger after the next edge, wrapping modulo 2^CNT_W. With `inc_i[i]` low the counter keeps its value.
- R3: While control bit 0 (freeze) is 1, no counter changes except through a software load.
- R4: A load with `wr_cnt_en_i` high puts `wr_cnt_data_i` into the counter chosen by `wr_cnt_sel_i` on the next edge. The load takes precedence over an increment of that counter in the same cycle.
- R5: A load with `wr_ctl_en_i` high puts `wr_ctl_data_i` into the control register on the next edge. Bit 0 is freeze, bit 1 is freeze-on-alert, bit 2 is alert-enable and bit 3 is alert-occurred.
- R6: An alert happens at an edge where any counter's bit CNT_W-1 changes from 0 to 1, through either an increment or a load. A counter that stays negative raises no further alert.
- R7: At an alert, if bit 1 is set (after any same-cycle control load), bit 1 is cleared and bit 0 is set in the same edge.
- R8: At an alert, if bit 2 is set (after any same-cycle control load), bit 2 is cleared and bit 3 is set in the same edge.
- R9: At an alert, a clear bit 1 or bit 2 leaves bits 0 to 3 unchanged, so each conversion happens only once.
- R10: Every alert sets `irq_o` in the same edge. `irq_o` stays high until a cycle with `irq_ack_i` high and no new alert, after which it is low.
- R11: In the first cycle `irq_o` is high, the counter outputs already show the values that caused the alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | NUM_CNT | Increment strobe, one per counter |
| wr_cnt_en_i | input | 1 | Software counter load strobe |
| wr_cnt_sel_i | input | SEL_W | Index of the counter to load |
| wr_cnt_data_i | input | CNT_W | Value to load into the chosen counter |
| wr_ctl_en_i | input | 1 | Software control register load strobe |
| wr_ctl_data_i | input | 4 | New control value (bit 0 freeze, 1 freeze-on-alert, 2 alert-enable, 3 alert-occurred) |
| irq_ack_i | input | 1 | Dispatcher acknowledge of the pending request |
| cnt_o | output | NUM_CNT*CNT_W | Counter values, counter i at bits i*CNT_W upward |
| ctl_o | output | 4 | Control register |
| irq_o | output | 1 | Pending interrupt request toward the branch dispatcher |

## Verification
The per-counter step and hold properties assume that a counter load occurs only when `wr_cnt_en_i` is raised. They also assume that no increment is lost, so a counter that is neither loaded nor frozen moves by exactly the strobe. The conversion properties are qualified on the absence of a same-cycle control load, because a load redefines the bits they watch. The stimulus meets this by mixing random strobes with sparse random loads. Some of those loads target values just below the sign boundary, so alerts happen together with freezes, control loads and acknowledges in the same cycle.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int CTL_W   = 4;
  localparam int CTL_FRZ = 0;
  localparam int CTL_FOA = 1;
  localparam int CTL_AEN = 2;
  localparam int CTL_AOC = 3;

  typedef struct packed {
    logic aoc;
    logic aen;
    logic foa;
    logic frz;
  } ctl_t;
endpackage

// File: rtl/pca_counter.sv
module pca_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  input  logic         frz_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         sign_rise_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)
      cnt_d = wdata_i;
    else if (inc_i && !frz_i)
      cnt_d = cnt_q + W'(1);
  end

  // negative edge detect on the value about to be stored
  assign sign_rise_o = cnt_d[W-1] & ~cnt_q[W-1];

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pca_ctrl.sv
module pca_ctrl
  import pca_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  ctl_t wdata_i,
  input  logic alert_i,
  output ctl_t ctl_o
);
  ctl_t ctl_q, base, ctl_d;

  always_comb begin
    base  = wr_i ? wdata_i : ctl_q;
    ctl_d = base;
    if (alert_i) begin
      if (base.foa) begin
        ctl_d.foa = 1'b0;
        ctl_d.frz = 1'b1;
      end
      if (base.aen) begin
        ctl_d.aen = 1'b0;
        ctl_d.aoc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/pca_irq.sv
module pca_irq (
  input  logic clk,
  input  logic rst,
  input  logic alert_i,
  input  logic ack_i,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (alert_i) pend_q <= 1'b1;
    else if (ack_i)   pend_q <= 1'b0;
  end

  assign irq_o = pend_q;
endmodule

// File: rtl/perf_alert_ctrl.sv
module perf_alert_ctrl
  import pca_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CNT-1:0]       inc_i,
  input  logic                     wr_cnt_en_i,
  input  logic [SEL_W-1:0]         wr_cnt_sel_i,
  input  logic [CNT_W-1:0]         wr_cnt_data_i,
  input  logic                     wr_ctl_en_i,
  input  logic [CTL_W-1:0]         wr_ctl_data_i,
  input  logic                     irq_ack_i,
  output logic [NUM_CNT*CNT_W-1:0] cnt_o,
  output logic [CTL_W-1:0]         ctl_o,
  output logic                     irq_o
);
  ctl_t               ctl;
  logic [NUM_CNT-1:0] rise_vec;
  logic               alert_any;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic sel_hit;
    assign sel_hit = wr_cnt_en_i && (wr_cnt_sel_i == SEL_W'(i));

    pca_counter #(.W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst         (rst),
      .inc_i       (inc_i[i]),
      .frz_i       (ctl.frz),
      .wr_i        (sel_hit),
      .wdata_i     (wr_cnt_data_i),
      .cnt_o       (cnt_o[i*CNT_W +: CNT_W]),
      .sign_rise_o (rise_vec[i])
    );
  end

  assign alert_any = |rise_vec;

  pca_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (wr_ctl_en_i),
    .wdata_i (ctl_t'(wr_ctl_data_i)),
    .alert_i (alert_any),
    .ctl_o   (ctl)
  );

  pca_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .alert_i (alert_any),
    .ack_i   (irq_ack_i),
    .irq_o   (irq_o)
  );

  assign ctl_o = ctl;
endmodule

// File: rtl/perf_alert_ctrl_chk.sv
module perf_alert_ctrl_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_CNT-1:0]       inc_i,
  input logic                     wr_cnt_en_i,
  input logic                     wr_ctl_en_i,
  input logic                     irq_ack_i,
  input logic [NUM_CNT*CNT_W-1:0] cnt_o,
  input logic [3:0]               ctl_o,
  input logic                     irq_o,
  input logic                     alert_any
);
  logic armed;
  logic [NUM_CNT-1:0] msb_vec;

  always_ff @(posedge clk) armed <= !rst;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_c
    assign msb_vec[i] = cnt_o[i*CNT_W + CNT_W - 1];

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(!ctl_o[0] && inc_i[i] && !wr_cnt_en_i))
      |-> cnt_o[i*CNT_W +: CNT_W] == $past(cnt_o[i*CNT_W +: CNT_W]) + CNT_W'(1));

    // R3
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(ctl_o[0] && !wr_cnt_en_i))
      |-> cnt_o[i*CNT_W +: CNT_W] == $past(cnt_o[i*CNT_W +: CNT_W]));
  end

  // R6
  alert_negative_chk: assert property (@(posedge clk) disable iff (rst)
    alert_any |=> (msb_vec != '0));

  // R7
  freeze_convert_chk: assert property (@(posedge clk) disable iff (rst)
    (alert_any && ctl_o[1] && !wr_ctl_en_i) |=> (ctl_o[0] && !ctl_o[1]));

  // R8
  alert_convert_chk: assert property (@(posedge clk) disable iff (rst)
    (alert_any && ctl_o[2] && !wr_ctl_en_i) |=> (ctl_o[3] && !ctl_o[2]));

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    alert_any |=> irq_o);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_ack_i) |=> irq_o);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && irq_ack_i && !alert_any) |=> !irq_o);
endmodule

bind perf_alert_ctrl perf_alert_ctrl_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .inc_i       (inc_i),
  .wr_cnt_en_i (wr_cnt_en_i),
  .wr_ctl_en_i (wr_ctl_en_i),
  .irq_ack_i   (irq_ack_i),
  .cnt_o       (cnt_o),
  .ctl_o       (ctl_o),
  .irq_o       (irq_o),
  .alert_any   (alert_any)
);

// File: tb/tb_perf_alert_ctrl.sv
`timescale 1ns/1ps
module tb_perf_alert_ctrl;
  localparam int N = 4;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   inc = '0;
  logic           wce = 1'b0;
  logic [1:0]     wsel = '0;
  logic [W-1:0]   wd = '0;
  logic           wte = 1'b0;
  logic [3:0]     wtd = '0;
  logic           ack = 1'b0;
  logic [N*W-1:0] cnt;
  logic [3:0]     ctl;
  logic           irq;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] ecnt [N];
  logic [3:0]   ectl;
  logic         eirq;

  perf_alert_ctrl #(.NUM_CNT(N), .CNT_W(W)) dut (
    .clk(clk), .rst(rst), .inc_i(inc), .wr_cnt_en_i(wce), .wr_cnt_sel_i(wsel),
    .wr_cnt_data_i(wd), .wr_ctl_en_i(wte), .wr_ctl_data_i(wtd),
    .irq_ack_i(ack), .cnt_o(cnt), .ctl_o(ctl), .irq_o(irq)
  );

  always #4 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    summary();
    $finish;
  end

  // expected next control value from R5, R7, R8, R9
  function automatic logic [3:0] next_ctl(input logic [3:0] cur, input logic we,
                                          input logic [3:0] d, input logic alert);
    logic [3:0] c;
    c = we ? d : cur;
    if (alert) begin
      if (c[1]) begin c[1] = 1'b0; c[0] = 1'b1; end
      if (c[2]) begin c[2] = 1'b0; c[3] = 1'b1; end
    end
    return c;
  endfunction

  task automatic compare(input string tag);
    for (int i = 0; i < N; i++) begin
      checks++;
      if (cnt[i*W +: W] !== ecnt[i]) begin
        fails++;
        $display("FAIL %s counter%0d actual %h expected %h", tag, i, cnt[i*W +: W], ecnt[i]);
      end
    end
    checks++;
    if (ctl !== ectl) begin
      fails++;
      $display("FAIL %s ctl actual %b expected %b", tag, ctl, ectl);
    end
    checks++;
    if (irq !== eirq) begin
      fails++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, eirq);
    end
  endtask

  task automatic cyc(input logic [N-1:0] i_inc, input logic i_wce, input logic [1:0] i_wsel,
                     input logic [W-1:0] i_wd, input logic i_wte, input logic [3:0] i_wtd,
                     input logic i_ack, input string tag);
    logic alert;
    logic [W-1:0] nx;
    @(negedge clk);
    inc = i_inc; wce = i_wce; wsel = i_wsel; wd = i_wd;
    wte = i_wte; wtd = i_wtd; ack = i_ack;
    alert = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (i_wce && i_wsel == 2'(i))       nx = i_wd;
      else if (i_inc[i] && !ectl[0])      nx = ecnt[i] + 32'd1;
      else                                nx = ecnt[i];
      if (nx[W-1] && !ecnt[i][W-1]) alert = 1'b1;
      ecnt[i] = nx;
    end
    ectl = next_ctl(ectl, i_wte, i_wtd, alert);
    eirq = alert | (eirq & ~i_ack);
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    void'($urandom(32'd20211108));
    for (int i = 0; i < N; i++) ecnt[i] = '0;
    ectl = '0; eirq = 1'b0;
    inc = '1;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    @(negedge clk);
    rst = 1'b0;
    inc = '0;

    // R2: plain counting, several patterns
    cyc(4'b0001, 0, 0, 0, 0, 0, 0, "R2");
    cyc(4'b0101, 0, 0, 0, 0, 0, 0, "R2");
    cyc(4'b1111, 0, 0, 0, 0, 0, 0, "R2");
    // R4 load wins over increment; R5 control load
    cyc(4'b1000, 1, 2'd3, 32'h1234_0000, 0, 0, 0, "R4");
    cyc(4'b0000, 1, 2'd1, 32'h7FFF_FFFF, 1, 4'b0110, 0, "R4/R5");
    // R6 R7 R8 R10 R11: increment crosses the sign boundary
    cyc(4'b0010, 0, 0, 0, 0, 0, 0, "R6/R7/R8/R10/R11");
    checks++;
    if (cnt[1*W +: W] !== 32'h8000_0000 || irq !== 1'b1) begin
      fails++;
      $display("FAIL R11 cnt1 actual %h expected 80000000 with irq %b", cnt[W +: W], irq);
    end
    // R3 frozen; R10 held without ack
    cyc(4'b1111, 0, 0, 0, 0, 0, 0, "R3/R10");
    cyc(4'b1111, 0, 0, 0, 0, 0, 1, "R3/R10 ack");
    // R3: a load still lands while frozen
    cyc(4'b1111, 1, 2'd0, 32'h0000_0050, 0, 0, 0, "R3/R4");
    // unfreeze; counter1 stays negative, no new alert (R6), bits stay (R9)
    cyc(4'b0000, 0, 0, 0, 1, 4'b0000, 0, "R5");
    cyc(4'b0010, 0, 0, 0, 0, 0, 0, "R6 stays negative");
    // R9: alert by load with conversion bits clear
    cyc(4'b0000, 1, 2'd2, 32'h8000_0000, 0, 0, 0, "R6/R9");
    // R10: ack in same cycle as a new alert keeps irq
    cyc(4'b0000, 1, 2'd3, 32'h7FFF_FFFF, 1, 4'b0100, 0, "R5");
    cyc(4'b1000, 0, 0, 0, 0, 0, 1, "R10 ack+alert");
    cyc(4'b0000, 0, 0, 0, 0, 0, 1, "R10 ack");
    // R9: one-shot, second alert leaves converted bits alone
    cyc(4'b0000, 1, 2'd0, 32'h7FFF_FFFF, 0, 0, 0, "R4");
    cyc(4'b0001, 0, 0, 0, 0, 0, 0, "R9 second alert");
    // R2: wrap around
    cyc(4'b0000, 1, 2'd1, 32'hFFFF_FFFF, 1, 4'b0000, 1, "R4/R5");
    cyc(4'b0010, 0, 0, 0, 0, 0, 0, "R2 wrap");

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r_inc;
      logic r_wce, r_wte, r_ack;
      logic [1:0] r_sel;
      logic [W-1:0] r_wd;
      logic [3:0] r_wtd;
      r_inc = N'($urandom);
      r_wce = ($urandom % 8) == 0;
      r_sel = 2'($urandom);
      case ($urandom % 4)
        0: r_wd = $urandom;
        1: r_wd = 32'h8000_0000;
        default: r_wd = 32'h7FFF_FFF8 + 32'($urandom % 8);
      endcase
      r_wte = ($urandom % 10) == 0;
      r_wtd = 4'($urandom);
      r_ack = ($urandom % 4) == 0;
      cyc(r_inc, r_wce, r_sel, r_wd, r_wte, r_wtd, r_ack, "R2/R3/R6/R7/R8/R10 random");
    end

    summary();
    $finish;
  end
endmodule